// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (2 Kbit)

This block models the serial side of a 2048-bit electrically erasable memory reached over a three-wire select/clock/data bus (Microwire style). A master raises the select line, clocks in a start bit, a two-bit opcode and an address, and then either clocks data in or reads data out. The memory is a register array inside the block. An organization input picks, at run time, whether the array is seen as 128 words of 16 bits or 256 words of 8 bits. The serial pins are oversampled by the system clock through synchronizers.

Programming (write, erase, erase-all, write-all) is self-timed. The cycle starts when select falls after a complete program instruction. It lasts a fixed number of system clocks, set by a parameter. While it runs, the block ignores every instruction. Raising select during or after the cycle shows a ready/busy flag on the data output. From reset, all programming is locked until an enable instruction arrives. A disable instruction locks it again.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, every storage bit reads as 1, and programming is locked.
- R2: While select is low the data output is disabled (sdoEn low). It is driven only during a read or while showing program status.
- R3: Zeros clocked before the first 1 are ignored. The 1 is the start bit, followed by opcode 10 (read), 01 (write), 11 (erase) or 00 (special). In the special group the top two address bits choose 11 enable, 00 disable, 10 erase-all or 01 write-all.
- R4: A read drives a dummy 0 after the last address bit. It then drives the word MSB first, one bit per rising serial clock.
- R5: A read with select held continues into the next word. The address wraps from the last word to word 0 in either organization.
- R6: With orgWide=1, 8 address bits are shifted in and bit 7 is don't-care. With orgWide=0, 9 bits are shifted in and bit 8 is don't-care. 8-bit byte 2w is the high byte of 16-bit word w, and byte 2w+1 is its low byte.
- R7: Write, erase, erase-all and write-all start no program cycle unless an enable was received and no later disable.
- R8: A write replaces the whole word with the shifted data, MSB first, clearing bits as well as setting them. The cycle begins when select falls after the last data bit.
- R9: After select falls on an enabled program instruction, raising select shows 0 while busy. It shows 1 once PROG_CYCLES system clocks have passed (a few clocks of pipeline allowed).
- R10: An instruction received while busy has no effect.
- R11: Erase sets the addressed word to all ones.
- R12: Erase-all sets every bit to 1. Write-all stores the shifted word into every word of the current organization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset (power-up) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the master |
| di | input | 1 | Serial data in |
| orgWide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words; tie high when unused |
| sdoData | output | 1 | Serial data out value |
| sdoEn | output | 1 | Output driver enable (low means high impedance) |

## Verification
A rising serial clock reaches the data output four system clocks after it appears on the pin: two synchronizer stages, one decode register and one output register. The bench therefore samples the output eight clocks after each rising edge it drives, and holds each serial level for twenty clocks. Status appears about three clocks after select rises. Ready is due PROG_CYCLES plus about four clocks after select falls, so the bench counts clocks from that fall and accepts ready only in the window from PROG_CYCLES to PROG_CYCLES+8. Read words go into a scoreboard. Their expected values come from a byte model that the bench updates only for instructions the requirements say take effect.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MEM_BITS  = 2048;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int NUM_BYTES = MEM_BITS / BYTE_W;
  localparam int BYTE_AW   = $clog2(NUM_BYTES);
  localparam int CNT_W     = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    OP_SPEC  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_t;

  typedef enum logic [1:0] {
    K_WRITE,
    K_ERASE,
    K_ERALL,
    K_WRALL
  } prog_kind_t;

  // strobes and operands handed from control to datapath
  typedef struct packed {
    logic                loadRead;
    logic                shiftRead;
    logic                commit;
    prog_kind_t          kind;
    logic                wide;
    logic [BYTE_AW-1:0]  addr;
    logic [WORD_W-1:0]   wdata;
  } ctrl_stb_t;
endpackage

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctrl_stb_t stb,
  output logic      outMsb
);
  logic [BYTE_W-1:0] mem [NUM_BYTES];
  logic [WORD_W-1:0] outShift;
  logic [WORD_W-1:0] rdWord;
  logic [BYTE_AW-1:0] evenIdx, oddIdx;

  always_comb begin
    evenIdx = {stb.addr[BYTE_AW-2:0], 1'b0};
    oddIdx  = {stb.addr[BYTE_AW-2:0], 1'b1};
    if (stb.wide) rdWord = {mem[evenIdx], mem[oddIdx]};
    else          rdWord = {mem[stb.addr], {BYTE_W{1'b0}}};
  end

  assign outMsb = outShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= '1;
    end else begin
      if (stb.loadRead)       outShift <= rdWord;
      else if (stb.shiftRead) outShift <= {outShift[WORD_W-2:0], 1'b0};

      if (stb.commit) begin
        case (stb.kind)
          K_WRITE: begin
            if (stb.wide) begin
              mem[evenIdx] <= stb.wdata[WORD_W-1:BYTE_W];
              mem[oddIdx]  <= stb.wdata[BYTE_W-1:0];
            end else begin
              mem[stb.addr] <= stb.wdata[BYTE_W-1:0];
            end
          end
          K_ERASE: begin
            if (stb.wide) begin
              mem[evenIdx] <= '1;
              mem[oddIdx]  <= '1;
            end else begin
              mem[stb.addr] <= '1;
            end
          end
          K_ERALL: begin
            for (int i = 0; i < NUM_BYTES; i++) mem[i] <= '1;
          end
          default: begin
            for (int i = 0; i < NUM_BYTES; i++)
              mem[i] <= (stb.wide && (i % 2 == 0)) ? stb.wdata[WORD_W-1:BYTE_W]
                                                   : stb.wdata[BYTE_W-1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 500000
)(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      skRise,
  input  logic      diS,
  input  logic      orgWide,
  input  logic      outMsb,
  output ctrl_stb_t stb,
  output logic      sdoData,
  output logic      sdoEn,
  output logic      busy,
  output logic      wen
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] SEL_EN    = 2'b11;
  localparam logic [1:0] SEL_DIS   = 2'b00;
  localparam logic [1:0] SEL_ERALL = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_ARMED, ST_DONE
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   bitCnt;
  opcode_t            op;
  logic [BYTE_AW-1:0] addrSh;
  logic [BYTE_AW-1:0] addrR;
  logic [WORD_W-1:0]  wdSh;
  prog_kind_t         kind;
  logic               wideR;
  logic               dout;
  logic               statusMode;
  logic [TW-1:0]      timer;
  logic               loadRd, shiftRd, commitR;

  logic [BYTE_AW:0]   fullAddr;
  logic [BYTE_AW-1:0] storeAddr;
  logic [1:0]         specSel;
  logic [CNT_W-1:0]   addrLast, dataLast;
  logic [BYTE_AW-1:0] wrapMask;

  always_comb begin
    fullAddr  = {addrSh, diS};
    storeAddr = wideR ? {1'b0, fullAddr[BYTE_AW-2:0]} : fullAddr[BYTE_AW-1:0];
    specSel   = wideR ? fullAddr[BYTE_AW-1 -: 2] : fullAddr[BYTE_AW -: 2];
    addrLast  = wideR ? CNT_W'(BYTE_AW - 1) : CNT_W'(BYTE_AW);
    dataLast  = wideR ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
    wrapMask  = wideR ? BYTE_AW'(NUM_BYTES / 2 - 1) : BYTE_AW'(NUM_BYTES - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      op         <= OP_SPEC;
      addrSh     <= '0;
      addrR      <= '0;
      wdSh       <= '0;
      kind       <= K_WRITE;
      wideR      <= 1'b1;
      dout       <= 1'b0;
      statusMode <= 1'b0;
      timer      <= '0;
      busy       <= 1'b0;
      wen        <= 1'b0;
      loadRd     <= 1'b0;
      shiftRd    <= 1'b0;
      commitR    <= 1'b0;
      sdoData    <= 1'b0;
      sdoEn      <= 1'b0;
    end else begin
      loadRd  <= 1'b0;
      shiftRd <= 1'b0;
      commitR <= 1'b0;

      if (busy) begin
        if (timer == '0) begin
          busy    <= 1'b0;
          commitR <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end

      if (!csS) begin
        if (state == ST_ARMED && wen && !busy) begin
          busy       <= 1'b1;
          timer      <= TW'(PROG_CYCLES - 1);
          statusMode <= 1'b1;
        end
        state <= ST_IDLE;
      end else if (busy) begin
        state <= ST_START;
      end else if (skRise) begin
        case (state)
          ST_IDLE, ST_START: begin
            if (diS) begin
              state      <= ST_OP;
              bitCnt     <= '0;
              wideR      <= orgWide;
              statusMode <= 1'b0;
            end else begin
              state <= ST_START;
            end
          end
          ST_OP: begin
            op <= opcode_t'({op[0], diS});
            if (bitCnt == CNT_W'(1)) begin
              state  <= ST_ADDR;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addrSh <= fullAddr[BYTE_AW-1:0];
            if (bitCnt == addrLast) begin
              bitCnt <= '0;
              addrR  <= storeAddr;
              case (op)
                OP_READ: begin
                  state  <= ST_READ;
                  dout   <= 1'b0;
                  loadRd <= 1'b1;
                end
                OP_WRITE: begin
                  kind  <= K_WRITE;
                  state <= ST_DATA;
                end
                OP_ERASE: begin
                  kind  <= K_ERASE;
                  state <= ST_ARMED;
                end
                default: begin
                  if (specSel == SEL_EN) begin
                    wen   <= 1'b1;
                    state <= ST_DONE;
                  end else if (specSel == SEL_DIS) begin
                    wen   <= 1'b0;
                    state <= ST_DONE;
                  end else if (specSel == SEL_ERALL) begin
                    kind  <= K_ERALL;
                    state <= ST_ARMED;
                  end else begin
                    kind  <= K_WRALL;
                    state <= ST_DATA;
                  end
                end
              endcase
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_DATA: begin
            wdSh <= {wdSh[WORD_W-2:0], diS};
            if (bitCnt == dataLast) state <= ST_ARMED;
            else                    bitCnt <= bitCnt + 1'b1;
          end
          ST_READ: begin
            dout <= outMsb;
            if (bitCnt == dataLast) begin
              bitCnt <= '0;
              addrR  <= (addrR + 1'b1) & wrapMask;
              loadRd <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 1'b1;
              shiftRd <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (state == ST_IDLE) begin
        state <= ST_START;
      end

      sdoEn   <= csS && ((state == ST_READ) ||
                         (statusMode && (state == ST_START || state == ST_IDLE)));
      sdoData <= (state == ST_READ) ? dout : !busy;
    end
  end

  always_comb begin
    stb.loadRead  = loadRd;
    stb.shiftRead = shiftRd;
    stb.commit    = commitR;
    stb.kind      = kind;
    stb.wide      = wideR;
    stb.addr      = addrR;
    stb.wdata     = wdSh;
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic orgWide,
  output logic sdoData,
  output logic sdoEn
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pinRaw;
  logic [NPINS-1:0] pinSync;
  logic             skPrev;
  logic             skRise;
  logic             csSync;
  logic             busy;
  logic             wen;
  logic             commitStb;
  logic             outMsb;
  ctrl_stb_t        stb;

  assign pinRaw = {cs, sk, di};

  for (genvar g = 0; g < NPINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinSync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) skPrev <= 1'b0;
    else       skPrev <= pinSync[1];
  end

  assign skRise    = pinSync[1] & ~skPrev;
  assign csSync    = pinSync[2];
  assign commitStb = stb.commit;

  mw_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csS     (csSync),
    .skRise  (skRise),
    .diS     (pinSync[0]),
    .orgWide (orgWide),
    .outMsb  (outMsb),
    .stb     (stb),
    .sdoData (sdoData),
    .sdoEn   (sdoEn),
    .busy    (busy),
    .wen     (wen)
  );

  mw_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .outMsb (outMsb)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic csSync,
  input logic busy,
  input logic wen,
  input logic commit,
  input logic sdoEn
);
  // R2: deselecting forces the driver off on the next clock
  a_r2_hiz_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !csSync |=> !sdoEn);

  // R7: a program cycle can only start with programming unlocked
  a_r7_prog_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> wen);

  // R10: nothing received while busy may touch the lock state
  a_r10_lock_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(wen));

  // R9: the storage update happens exactly as the busy window closes
  a_r9_commit_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> ($past(busy) && !busy));

  // R8: one update per program cycle
  a_r8_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !commit);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csSync (csSync),
  .busy   (busy),
  .wen    (wen),
  .commit (commitStb),
  .sdoEn  (sdoEn)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, orgWide = 1'b1;
  logic sdoData, sdoEn;
  logic lastSdo, lastEn;
  logic [7:0] model [256];
  int unsigned nChk = 0, nFail = 0;
  bit done = 0;

  typedef struct {
    int unsigned val;
    string       req;
  } exp_t;
  exp_t        expQ[$];
  int unsigned actQ[$];

  mw_eeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .sk(sk), .di(di),
    .orgWide(orgWide), .sdoData(sdoData), .sdoEn(sdoEn)
  );

  always #10 clk = ~clk;  // 20 ns period: 50 MHz

  task automatic check(bit ok, string req, int unsigned act, int unsigned expv, string what);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic clkWait(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int unsigned modelWord(bit wide, int unsigned i);
    if (wide) return {16'h0, model[2*i], model[2*i+1]};
    return {24'h0, model[i]};
  endfunction

  task automatic modelWrite(bit wide, int unsigned i, int unsigned d);
    if (wide) begin
      model[2*i]   = d[15:8];
      model[2*i+1] = d[7:0];
    end else model[i] = d[7:0];
  endtask

  task automatic bitOut(logic b);
    di = b;
    clkWait(4);
    sk = 1'b1;
    clkWait(8);
    lastSdo = sdoData;
    lastEn  = sdoEn;
    sk = 1'b0;
    clkWait(8);
  endtask

  task automatic csOn();
    cs = 1'b1;
    clkWait(4);
  endtask

  task automatic csOff();
    cs = 1'b0;
    sk = 1'b0;
    clkWait(8);
  endtask

  // R3: a leading zero precedes every start bit and must be ignored
  task automatic sendHead(logic [1:0] op, int unsigned raw, int nA);
    csOn();
    bitOut(1'b0);
    bitOut(1'b1);
    bitOut(op[1]);
    bitOut(op[0]);
    for (int i = nA - 1; i >= 0; i--) bitOut(logic'((raw >> i) & 1));
  endtask

  task automatic sendData(int unsigned d, int len);
    for (int i = len - 1; i >= 0; i--) bitOut(logic'((d >> i) & 1));
  endtask

  // select falls, then rises again to watch status
  task automatic progEnd(bit expectProg, string req);
    int t;
    cs = 1'b0;
    sk = 1'b0;
    clkWait(8);
    cs = 1'b1;
    clkWait(8);
    t = 16;
    if (expectProg) begin
      check(sdoEn == 1'b1 && sdoData == 1'b0, "R9", {sdoEn, sdoData}, 2'b10, "busy status");
      while (sdoData !== 1'b1 && t < PROG + 500) begin
        clkWait(1);
        t++;
      end
      check(t >= PROG && t <= PROG + 8, "R9", t, PROG, "ready delay");
    end else begin
      check(sdoEn == 1'b0, req, sdoEn, 0, "no program cycle started");
    end
    csOff();
  endtask

  task automatic readCmd(bit wide, int unsigned raw, int n, string req);
    int nA = wide ? 8 : 9;
    int wl = wide ? 16 : 8;
    int unsigned depth = wide ? 128 : 256;
    int unsigned idx = raw % depth;
    int unsigned word;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.val = modelWord(wide, idx);
      e.req = req;
      expQ.push_back(e);
      idx = (idx + 1) % depth;
    end
    sendHead(2'b10, raw, nA);
    check(lastEn == 1'b1 && lastSdo == 1'b0, "R4", {lastEn, lastSdo}, 2'b10, "dummy bit");
    for (int k = 0; k < n; k++) begin
      word = 0;
      for (int b = 0; b < wl; b++) begin
        bitOut(1'b0);
        word = (word << 1) | int'(lastSdo);
      end
      actQ.push_back(word);
    end
    csOff();
    check(sdoEn == 1'b0, "R2", sdoEn, 0, "output released after deselect");
  endtask

  task automatic special(bit wide, logic [1:0] sel);
    int nA = wide ? 8 : 9;
    sendHead(2'b00, int'(sel) << (nA - 2), nA);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    int unsigned a;
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        e = expQ.pop_front();
        a = actQ.pop_front();
        check(a == e.val, e.req, a, e.val, "read word");
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    clkWait(5);
    rstN = 1'b1;
    clkWait(5);
    check(sdoEn == 1'b0, "R1", sdoEn, 0, "output disabled after reset");
    csOn();
    clkWait(8);
    check(sdoEn == 1'b0, "R2", sdoEn, 0, "selected but idle stays undriven");
    csOff();

    // R7 / R1: locked at reset
    sendHead(2'b01, 5, 8);
    sendData(16'h1234, 16);
    progEnd(0, "R7");
    readCmd(1, 5, 1, "R1");

    // R3: enable (special 11), then write with status polling
    special(1, 2'b11);
    csOff();
    sendHead(2'b01, 5, 8);
    sendData(16'hA5C3, 16);
    progEnd(1, "R8");
    modelWrite(1, 5, 16'hA5C3);
    readCmd(1, 5, 1, "R8");
    readCmd(1, 5 | 8'h80, 1, "R6");

    // R8: overwrite sets and clears bits
    sendHead(2'b01, 5, 8);
    sendData(16'h5A3C, 16);
    progEnd(1, "R8");
    modelWrite(1, 5, 16'h5A3C);
    readCmd(1, 5, 1, "R8");

    // R10: write while busy is ignored
    sendHead(2'b01, 9, 8);
    sendData(16'h1111, 16);
    cs = 1'b0;
    clkWait(8);
    sendHead(2'b01, 10, 8);
    sendData(16'h2222, 16);
    csOff();
    csOn();
    begin
      int t = 0;
      while (sdoData !== 1'b1 && t < 3 * PROG) begin
        clkWait(1);
        t++;
      end
    end
    csOff();
    modelWrite(1, 9, 16'h1111);
    readCmd(1, 10, 1, "R10");
    readCmd(1, 9, 1, "R10");

    // R6: byte mode, A8 set as don't-care
    orgWide = 1'b0;
    sendHead(2'b01, 9'h100 | 9'h0B, 9);
    sendData(8'h77, 8);
    progEnd(1, "R6");
    modelWrite(0, 11, 8'h77);
    readCmd(0, 11, 1, "R6");
    orgWide = 1'b1;
    readCmd(1, 5, 1, "R6");

    // R5: sequential reads across the wrap
    sendHead(2'b01, 127, 8);
    sendData(16'hBEEF, 16);
    progEnd(1, "R8");
    modelWrite(1, 127, 16'hBEEF);
    sendHead(2'b01, 0, 8);
    sendData(16'hCAFE, 16);
    progEnd(1, "R8");
    modelWrite(1, 0, 16'hCAFE);
    readCmd(1, 126, 4, "R5");
    orgWide = 1'b0;
    readCmd(0, 255, 2, "R5");
    orgWide = 1'b1;

    // R11: erase a word
    sendHead(2'b11, 127, 8);
    progEnd(1, "R11");
    modelWrite(1, 127, 16'hFFFF);
    readCmd(1, 127, 1, "R11");

    // R12: write-all then erase-all
    special(1, 2'b01);
    sendData(16'h6A95, 16);
    progEnd(1, "R12");
    for (int w = 0; w < 128; w++) modelWrite(1, w, 16'h6A95);
    readCmd(1, 0, 1, "R12");
    readCmd(1, 127, 2, "R12");
    special(1, 2'b10);
    progEnd(1, "R12");
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    readCmd(1, 64, 1, "R12");

    // R7: disable restores the lock
    special(1, 2'b00);
    csOff();
    sendHead(2'b01, 3, 8);
    sendData(16'h1234, 16);
    progEnd(0, "R7");
    readCmd(1, 3, 1, "R7");

    clkWait(20);
    check(expQ.size() == 0, "R4", expQ.size(), 0, "scoreboard drained");
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule